// File: doc/BRIEF.md
# Sub-blocked Direct-Mapped Cache

This block is a 1 KB direct-mapped cache controller for 32-bit byte addresses. It has 32 lines of 32 bytes each. Each line is divided into four 8-byte sub-blocks, and every sub-block has its own valid flag. One stored tag is shared by the whole line. On a miss only the touched sub-block is fetched from the next memory level, so a line can be partly present. When a fill brings in a different tag, the flags of the other sub-blocks in that line are dropped.

The processor side presents one 32-bit word access at a time and holds it until `cpuReady` is seen. The request carries a byte address, a write flag and byte enables. A read hit finishes in the cycle it is presented. A miss stalls the port while one 8-byte sub-block is read from memory, and the access then finishes as a hit.

Stores are write-through. Every store also goes out to memory as one word write with byte enables, and no line ever holds data that differs from memory. A store that misses first fetches its sub-block, then merges its bytes into the cache and writes them to memory. The memory side is a single request channel. The request is held with stable address and kind until the memory answers with a one-cycle ready pulse; for a read, that pulse also carries the data.

Top module: `sbc_cache`

## Requirements
- R1: Reset clears every valid flag, so the first access to any address misses. While reset is released and no request is present, `cpuReady`, `cpuHit` and `memReq` are low.
- R2: Address bits [9:5] choose the line and bits [31:10] are compared with the stored tag. Two addresses with the same line bits and different tags displace each other.
- R3: A miss raises exactly one memory read. That read has `memWe` low and `memAddr` equal to the request address with bits [2:0] cleared. Bits [31:0] of the returned 64-bit `memRData` are the word at the lower address. `memReq`, `memWe` and `memAddr` stay unchanged until `memReady` is seen.
- R4: From a miss until the fill is taken, `cpuReady` stays low. In the cycle after the `memReady` pulse of a fill, the held request hits. With a memory that answers L cycles after the request appears, a read miss finishes L+1 cycles after it is presented.
- R5: A hit needs both a tag match and a set valid flag for the sub-block chosen by address bits [4:3]. A sub-block that has not been fetched misses even when the line holds the right tag.
- R6: A fill that writes a new tag clears the valid flags of the other three sub-blocks of that line. A fill under the tag already stored keeps them.
- R7: Every store produces one memory write. That write has `memWe` high, `memAddr` equal to the request address with bits [1:0] cleared, and `memWData`/`memBe` equal to `cpuWData`/`cpuBe`. The store finishes (`cpuReady` high) in the cycle `memReady` is high. A store that hits finishes L cycles after it is presented.
- R8: A store that misses first fills its sub-block as in R3, then performs the write as in R7, and finishes 2L+1 cycles after it is presented. Later reads of that sub-block return the stored bytes merged with the fetched ones.
- R9: A store changes only the bytes whose enable is set. `cpuBe[i]` covers `cpuWData[8i+7:8i]`, and byte i sits at address offset i within the word.
- R10: A read hit raises `cpuHit` and `cpuReady` in the cycle the request is presented and raises no memory request. `cpuRData` is the low half of the sub-block when address bit 2 is 0, and the high half otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor access present, held until cpuReady |
| cpuWe | input | 1 | Access is a store |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWData | input | 32 | Store data |
| cpuBe | input | 4 | Store byte enables |
| cpuReady | output | 1 | Access finishes this cycle |
| cpuHit | output | 1 | Presented access hits in the idle lookup |
| cpuRData | output | 32 | Read data, valid with cpuReady on a read |
| memReq | output | 1 | Memory transaction requested |
| memWe | output | 1 | Memory transaction is a word write |
| memAddr | output | 32 | Sub-block address for reads, word address for writes |
| memWData | output | 32 | Write data to memory |
| memBe | output | 4 | Write byte enables to memory |
| memReady | input | 1 | One-cycle reply from memory |
| memRData | input | 64 | Sub-block data returned on a read reply |

## Verification
A corrupted valid flag or tag becomes visible at the first later access to that line. The symptoms are a `cpuHit` in the wrong sense in the presentation cycle, a memory read that should not occur (or is missing), and a finish time that deviates by L+1 cycles. A flag left set under a replaced tag is the most dangerous case, because the port returns data from the old tag with no stall. The bench therefore checks read data against its own copy of memory on every read. It reads sub-blocks again after tag changes. A wrong byte merge stays hidden until that word is read back, either from the cache or, after eviction, from memory, so the bench reads stored words back both ways.

// File: rtl/sbc_cache_pkg.sv
package sbc_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WMEM = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic fillWe;
    logic storeWe;
  } dpStrobe_t;

endpackage

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SUB_BYTES  = 8,
  parameter int NUM_LINES  = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          strobe,
  input  logic [ADDR_W-$clog2(WORD_BYTES)-1:0] addrWord,
  input  logic [WORD_BYTES*8-1:0]            wData,
  input  logic [WORD_BYTES-1:0]              byteEn,
  input  logic [SUB_BYTES*8-1:0]             fillData,
  output logic                               lookupHit,
  output logic [WORD_BYTES*8-1:0]            rdWord
);

  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int SB_N     = LINE_BYTES / SUB_BYTES;
  localparam int SB_W     = $clog2(SB_N);
  localparam int SUBOFF_W = $clog2(SUB_BYTES);
  localparam int WOFF_W   = $clog2(WORD_BYTES);
  localparam int WORD_W   = WORD_BYTES * 8;
  localparam int SUB_W    = SUB_BYTES * 8;
  localparam int WSEL_W   = SUBOFF_W - WOFF_W;
  localparam int AW_W     = ADDR_W - WOFF_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [SB_W-1:0]   sb;
  logic [WSEL_W-1:0] wsel;

  assign idx  = addrWord[OFF_W-WOFF_W +: IDX_W];
  assign tag  = addrWord[AW_W-1 -: TAG_W];
  assign sb   = addrWord[SUBOFF_W-WOFF_W +: SB_W];
  assign wsel = addrWord[0 +: WSEL_W];

  logic [TAG_W-1:0] tagArr   [NUM_LINES];
  logic [SB_N-1:0]  validArr [NUM_LINES];
  logic [SUB_W-1:0] dataArr  [NUM_LINES][SB_N];

  logic             tagMatch;
  logic [SUB_W-1:0] subWord;
  logic [WORD_W-1:0] curWord;
  logic [SB_N-1:0]  sbOneHot;

  assign tagMatch  = (tagArr[idx] == tag);
  assign lookupHit = tagMatch && validArr[idx][sb];
  assign subWord   = dataArr[idx][sb];
  assign curWord   = subWord[int'(wsel)*WORD_W +: WORD_W];
  assign rdWord    = curWord;
  assign sbOneHot  = SB_N'(1) << sb;

  // byte lanes of the store, merged with the word already held
  logic [WORD_BYTES-1:0][7:0] mergedWord;
  for (genvar gb = 0; gb < WORD_BYTES; gb++) begin : g_lane
    assign mergedWord[gb] = byteEn[gb] ? wData[gb*8 +: 8] : curWord[gb*8 +: 8];
  end

  logic [SUB_W-1:0] storeMerged;
  always_comb begin
    storeMerged = subWord;
    storeMerged[int'(wsel)*WORD_W +: WORD_W] = mergedWord;
  end

  // valid flags: a fill under a new tag keeps only the fetched sub-block
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINES; l++) validArr[l] <= '0;
    end else if (strobe.fillWe) begin
      validArr[idx] <= tagMatch ? (validArr[idx] | sbOneHot) : sbOneHot;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWe) begin
      tagArr[idx]      <= tag;
      dataArr[idx][sb] <= fillData;
    end else if (strobe.storeWe) begin
      dataArr[idx][sb] <= storeMerged;
    end
  end

endmodule

// File: rtl/sbc_control.sv
module sbc_control
  import sbc_cache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      lookupHit,
  input  logic      memReady,
  output dpStrobe_t strobe,
  output logic      cpuReady,
  output logic      cpuHit,
  output logic      memReq,
  output logic      memWe
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe.fillWe  = 1'b0;
    strobe.storeWe = 1'b0;
    cpuReady       = 1'b0;
    cpuHit         = 1'b0;
    memReq         = 1'b0;
    memWe          = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuHit = cpuReq && lookupHit;
        if (cpuReq) begin
          if (!lookupHit)  stateNext = ST_FILL;
          else if (cpuWe)  stateNext = ST_WMEM;
          else             cpuReady  = 1'b1;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memReady) begin
          strobe.fillWe = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_WMEM: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          strobe.storeWe = 1'b1;
          cpuReady       = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sbc_cache.sv
module sbc_cache
  import sbc_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SUB_BYTES  = 8,
  parameter int NUM_LINES  = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuReq,
  input  logic                      cpuWe,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [WORD_BYTES*8-1:0]   cpuWData,
  input  logic [WORD_BYTES-1:0]     cpuBe,
  output logic                      cpuReady,
  output logic                      cpuHit,
  output logic [WORD_BYTES*8-1:0]   cpuRData,
  output logic                      memReq,
  output logic                      memWe,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [WORD_BYTES*8-1:0]   memWData,
  output logic [WORD_BYTES-1:0]     memBe,
  input  logic                      memReady,
  input  logic [SUB_BYTES*8-1:0]    memRData
);

  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] SUB_MASK  = ADDR_W'(SUB_BYTES - 1);
  localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(WORD_BYTES - 1);

  dpStrobe_t strobe;
  logic      lookupHit;

  sbc_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cpuWe     (cpuWe),
    .lookupHit (lookupHit),
    .memReady  (memReady),
    .strobe    (strobe),
    .cpuReady  (cpuReady),
    .cpuHit    (cpuHit),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  sbc_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .SUB_BYTES  (SUB_BYTES),
    .NUM_LINES  (NUM_LINES),
    .WORD_BYTES (WORD_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addrWord  (cpuAddr[ADDR_W-1:WOFF_W]),
    .wData     (cpuWData),
    .byteEn    (cpuBe),
    .fillData  (memRData),
    .lookupHit (lookupHit),
    .rdWord    (cpuRData)
  );

  assign memAddr  = memWe ? (cpuAddr & ~WORD_MASK) : (cpuAddr & ~SUB_MASK);
  assign memWData = cpuWData;
  assign memBe    = cpuBe;

endmodule

// File: rtl/sbc_cache_chk.sv
module sbc_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              cpuHit,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady
);

  // R4: a read that misses cannot finish while it misses
  p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && !cpuHit) |-> !cpuReady);

  // R4: the cycle after a fill is taken, a held request hits
  p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memReady && cpuReq) |=> (!cpuReq || cpuHit));

  // R3: fills fetch whole aligned sub-blocks
  p_fill_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr[2:0] == 3'b000));

  // R3: a memory request is held unchanged until answered
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R7: a store only finishes together with its memory write
  p_store_mem_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && cpuReady) |-> (memReq && memWe && memReady));

  // R10: a read hit finishes at once without touching memory
  p_read_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && cpuHit) |-> (cpuReady && !memReq));

endmodule

bind sbc_cache sbc_cache_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuReady (cpuReady),
  .cpuHit   (cpuHit),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memReady (memReady)
);

// File: tb/tb_sbc_cache.sv
`timescale 1ns/1ps
module tb_sbc_cache;

  localparam int LAT   = 3;
  localparam int NVEC  = 22;
  localparam int MWORDS = 1024;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        expHit;
    logic [3:0]  req;
  } vec_t;

  // we, addr, wdata, be, hit at presentation, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h000, 32'h0, 4'h0, 1'b0, 4'd1},          // R1 cold miss
    '{1'b0, 32'h004, 32'h0, 4'h0, 1'b1, 4'd10},         // R10 high word, same sub-block
    '{1'b0, 32'h008, 32'h0, 4'h0, 1'b0, 4'd5},          // R5 unfetched sub-block
    '{1'b0, 32'h000, 32'h0, 4'h0, 1'b1, 4'd6},          // R6 same-tag fill kept sb0
    '{1'b0, 32'h400, 32'h0, 4'h0, 1'b0, 4'd2},          // R2 same line, new tag
    '{1'b0, 32'h408, 32'h0, 4'h0, 1'b0, 4'd6},          // R6 stale flag dropped
    '{1'b0, 32'h000, 32'h0, 4'h0, 1'b0, 4'd2},          // R2 evicted
    '{1'b0, 32'h008, 32'h0, 4'h0, 1'b0, 4'd6},          // R6 cleared again
    '{1'b1, 32'h010, 32'hCAFE1234, 4'b0011, 1'b0, 4'd8},// R8 store miss
    '{1'b0, 32'h010, 32'h0, 4'h0, 1'b1, 4'd8},          // R8 merged read
    '{1'b1, 32'h014, 32'h77000000, 4'b1000, 1'b1, 4'd9},// R9 store hit, one byte
    '{1'b0, 32'h014, 32'h0, 4'h0, 1'b1, 4'd9},          // R9
    '{1'b0, 32'h3E0, 32'h0, 4'h0, 1'b0, 4'd2},          // R2 last line
    '{1'b0, 32'h3E4, 32'h0, 4'h0, 1'b1, 4'd10},         // R10
    '{1'b0, 32'h3FC, 32'h0, 4'h0, 1'b0, 4'd5},          // R5 last sub-block
    '{1'b0, 32'h3F8, 32'h0, 4'h0, 1'b1, 4'd10},         // R10 low word
    '{1'b1, 32'h020, 32'h89ABCDEF, 4'b1111, 1'b0, 4'd8},// R8 full word store miss
    '{1'b0, 32'h024, 32'h0, 4'h0, 1'b1, 4'd8},          // R8 fetched neighbour
    '{1'b1, 32'h004, 32'h11223344, 4'b0101, 1'b1, 4'd9},// R9 alternate bytes
    '{1'b0, 32'h004, 32'h0, 4'h0, 1'b1, 4'd9},          // R9
    '{1'b0, 32'hC00, 32'h0, 4'h0, 1'b0, 4'd2},          // R2 third tag
    '{1'b0, 32'h010, 32'h0, 4'h0, 1'b0, 4'd7}           // R7 stored bytes reached memory
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic [3:0]  cpuBe = '0;
  logic        cpuReady, cpuHit;
  logic [31:0] cpuRData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWData;
  logic [3:0]  memBe;
  logic        memReady = 1'b0;
  logic [63:0] memRData = '0;

  always #2 clk = ~clk;

  sbc_cache dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWData(cpuWData), .cpuBe(cpuBe),
    .cpuReady(cpuReady), .cpuHit(cpuHit), .cpuRData(cpuRData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData), .memBe(memBe),
    .memReady(memReady), .memRData(memRData)
  );

  logic [31:0] mem    [MWORDS];
  logic [31:0] refMem [MWORDS];
  int nChecks = 0;
  int nFail   = 0;
  int rdCount = 0;
  int wrCount = 0;
  logic [31:0] lastRdAddr = '0;
  bit done = 0;

  function automatic logic [31:0] initWord(int i);
    return (32'(i) * 32'h0103_0507) ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input bit ok, input int r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // memory model: answers LAT cycles after a request appears
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (memReady) begin
        memReady = 1'b0;
        cnt = 0;
      end else if (memReq) begin
        cnt++;
        if (cnt == LAT) begin
          memReady = 1'b1;
          if (memWe) begin
            for (int b = 0; b < 4; b++)
              if (memBe[b]) mem[memAddr[11:2]][b*8 +: 8] = memWData[b*8 +: 8];
            wrCount++;
          end else begin
            memRData = {mem[{memAddr[11:3], 1'b1}], mem[{memAddr[11:3], 1'b0}]};
            lastRdAddr = memAddr;
            rdCount++;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual expired expected done");
    finishRun();
  end

  task automatic doAccess(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, input logic expHit, input int r);
    int rd0, wr0, cyc, expCyc;
    logic hitSeen;
    logic [31:0] dataSeen;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWData = wd; cpuBe = be;
    rd0 = rdCount; wr0 = wrCount;
    if (we)
      for (int b = 0; b < 4; b++)
        if (be[b]) refMem[addr[11:2]][b*8 +: 8] = wd[b*8 +: 8];
    #1;
    hitSeen = cpuHit;
    cyc = 0;
    while (!cpuReady && cyc < 60) begin
      @(negedge clk); #1;
      cyc++;
    end
    dataSeen = cpuRData;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
    // hit flag in the presentation cycle (R1, R2, R5, R6 by vector)
    chk(hitSeen == expHit, r, "hit at presentation", 64'(hitSeen), 64'(expHit));
    // finish time: R10 read hit 0, R4 read miss LAT+1, R7 store hit LAT, R8 store miss 2LAT+1
    expCyc = we ? (expHit ? LAT : 2*LAT + 1) : (expHit ? 0 : LAT + 1);
    chk(cyc == expCyc, we ? (expHit ? 7 : 8) : (expHit ? 10 : 4), "cycles to ready",
        64'(cyc), 64'(expCyc));
    // R3: one aligned fill read per miss, none per hit
    chk(rdCount - rd0 == (expHit ? 0 : 1), 3, "memory reads", 64'(rdCount - rd0),
        64'(expHit ? 0 : 1));
    if (!expHit)
      chk(lastRdAddr == {addr[31:3], 3'b000}, 3, "fill address", 64'(lastRdAddr),
          64'({addr[31:3], 3'b000}));
    // R7: one memory write per store, content matches
    chk(wrCount - wr0 == (we ? 1 : 0), 7, "memory writes", 64'(wrCount - wr0), 64'(we));
    if (we)
      chk(mem[addr[11:2]] == refMem[addr[11:2]], 7, "memory word after store",
          64'(mem[addr[11:2]]), 64'(refMem[addr[11:2]]));
    else
      chk(dataSeen == refMem[addr[11:2]], r, "read data", 64'(dataSeen),
          64'(refMem[addr[11:2]]));
  endtask

  initial begin
    for (int i = 0; i < MWORDS; i++) begin
      mem[i]    = initWord(i);
      refMem[i] = initWord(i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: idle outputs after reset
    chk(!cpuReady, 1, "cpuReady after reset", 64'(cpuReady), 64'(0));
    chk(!cpuHit,   1, "cpuHit after reset",   64'(cpuHit),   64'(0));
    chk(!memReq,   1, "memReq after reset",   64'(memReq),   64'(0));

    for (int v = 0; v < NVEC; v++)
      doAccess(VECS[v].we, VECS[v].addr, VECS[v].wdata, VECS[v].be,
               VECS[v].expHit, int'(VECS[v].req));

    // R1: a second reset drops lines that were present
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doAccess(1'b0, 32'h024, 32'h0, 4'h0, 1'b0, 1);
    doAccess(1'b0, 32'hC04, 32'h0, 4'h0, 1'b0, 1);
    doAccess(1'b0, 32'hC04, 32'h0, 4'h0, 1'b1, 10);
    // R5: other sub-blocks of a just-filled line still miss
    doAccess(1'b0, 32'h03C, 32'h0, 4'h0, 1'b0, 5);
    // R6: same-tag fill keeps sub-block 0 and 3 present together
    doAccess(1'b0, 32'h020, 32'h0, 4'h0, 1'b1, 6);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule